// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block owns the fetch address of a small 32-bit processor. Each cycle it takes the decoded flow-control kind of the instruction now at the program counter, together with the comparison result of its two register operands, its immediates and a register-sourced target. From these it selects the address of the next instruction. For linking jumps it also presents the return address and the register index that should receive it.

The register file and instruction memory sit outside the block. The decoder drives `flow_i` with a 3-bit kind code. The register file compares the two source operands and drives `ops_equal_i`, and supplies the jump register value on `reg_tgt_i`. The link outputs are combinational for the instruction at `pc_o`, so they can feed the register file write port in the same cycle. A stall freezes the unit for that cycle. The unit has no delay slot: a taken transfer redirects the very next fetch.

Top module: `pcseq_unit`

## Requirements
- R1: While `rst_n` is low, the PC register loads 0x80000000, and `pc_o` shows that value from the first edge after reset is applied.
- R2: With `flow_i` = 0 (sequential) and no stall, `pc_o` advances by 4 on each clock edge, wrapping modulo 2^32.
- R3: A taken branch loads `pc_o + 4 + 4*sign_extend(br_off_i)`, so an offset of 0xFFFF makes the PC stay on the branch itself.
- R4: `flow_i` = 1 is taken only when `ops_equal_i` is 1, and `flow_i` = 2 is taken only when `ops_equal_i` is 0. An untaken branch steps the PC by 4.
- R5: `flow_i` = 3 (absolute jump) and `flow_i` = 4 (absolute jump with link) load {bits [31:28] of `pc_o + 4`, `jmp_idx_i`, 2'b00}.
- R6: `flow_i` = 5 (register jump) and `flow_i` = 6 (register jump with link) load the full 32-bit `reg_tgt_i`.
- R7: For `flow_i` = 4, `link_we_o` is 1, `link_idx_o` is 31 and `link_val_o` equals `pc_o + 4`.
- R8: For `flow_i` = 6, `link_we_o` is 1, `link_idx_o` equals `link_dst_i` and `link_val_o` equals `pc_o + 4`.
- R9: For `flow_i` = 6 with `link_dst_i` = 0, `link_idx_o` is 31.
- R10: When `stall_i` is 1, `pc_o` keeps its value across the edge, whatever `flow_i` says.
- R11: When `stall_i` is 1, `link_we_o` is 0.
- R12: For `flow_i` values 0, 1, 2, 3, 5 and the unused code 7, `link_we_o` is 0. Code 7 steps the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stall_i | input | 1 | Hold the PC and suppress the link write this cycle |
| flow_i | input | 3 | Flow kind: 0 seq, 1 branch-equal, 2 branch-not-equal, 3 abs jump, 4 abs jump+link, 5 reg jump, 6 reg jump+link |
| ops_equal_i | input | 1 | The two register operands compare equal |
| br_off_i | input | 16 | Signed branch offset in words |
| jmp_idx_i | input | 26 | Word index for absolute jumps |
| reg_tgt_i | input | 32 | Target address from a register |
| link_dst_i | input | 5 | Destination register for the register jump with link |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Write the return address this cycle |
| link_idx_o | output | 5 | Register index that receives the return address |
| link_val_o | output | 32 | Return address (PC + 4) |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 4-byte step, region bits taken from the incremented PC, and a zero link destination mapped to register 31. These defaults bring the region boundary into reach. A register jump to 0x8FFFFFFC followed by an absolute jump shows that the region nibble comes from 0x90000000 and not from the current PC. A self-branch with offset 0xFFFF, a backward branch, and a register jump with a zero destination cover the remaining corners.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   typedef enum logic [2:0] {
      FLOW_SEQ       = 3'd0,
      FLOW_BR_EQ     = 3'd1,
      FLOW_BR_NE     = 3'd2,
      FLOW_JABS      = 3'd3,
      FLOW_JABS_LINK = 3'd4,
      FLOW_JREG      = 3'd5,
      FLOW_JREG_LINK = 3'd6,
      FLOW_RSVD      = 3'd7
   } flow_e;

   localparam int FLOW_W = 3;

endpackage

// File: rtl/pcseq_incr.sv
module pcseq_incr #(
   parameter int XLEN = 32,
   parameter int STEP = 4
) (
   input  logic [XLEN-1:0] pc_i,
   output logic [XLEN-1:0] pc_plus_o
);
   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   if (STEP < 1) begin : g_bad_step
      $error("pcseq_incr: STEP must be positive");
   end

   always_comb pc_plus_o = pc_i + STEP_V;

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
   parameter int XLEN          = 32,
   parameter int STEP          = 4,
   parameter int OFF_W         = 16,
   parameter int IDX_W         = 26,
   parameter int REGION_W      = 4,
   parameter bit REGION_FROM_NEXT = 1'b1
) (
   input  logic [XLEN-1:0]  pc_i,
   input  logic [XLEN-1:0]  pc_plus_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [XLEN-1:0]  br_tgt_o,
   output logic [XLEN-1:0]  jabs_tgt_o
);
   localparam int SHIFT  = $clog2(STEP);
   localparam int EXT_W  = XLEN - OFF_W - SHIFT;

   if ((1 << SHIFT) != STEP) begin : g_bad_step
      $error("pcseq_target: STEP must be a power of two");
   end
   if (REGION_W + IDX_W + SHIFT != XLEN) begin : g_bad_split
      $error("pcseq_target: region, index and shift must fill XLEN");
   end
   if (EXT_W < 0) begin : g_bad_off
      $error("pcseq_target: branch offset too wide");
   end

   logic [XLEN-1:0]     off_scaled;
   logic [REGION_W-1:0] region;

   if (SHIFT > 0) begin : g_shift
      always_comb off_scaled = {{EXT_W{off_i[OFF_W-1]}}, off_i, {SHIFT{1'b0}}};
      always_comb jabs_tgt_o = {region, idx_i, {SHIFT{1'b0}}};
   end else begin : g_noshift
      always_comb off_scaled = {{EXT_W{off_i[OFF_W-1]}}, off_i};
      always_comb jabs_tgt_o = {region, idx_i};
   end

   if (REGION_FROM_NEXT) begin : g_region_next
      always_comb region = pc_plus_i[XLEN-1 -: REGION_W];
   end else begin : g_region_cur
      always_comb region = pc_i[XLEN-1 -: REGION_W];
   end

   always_comb br_tgt_o = pc_plus_i + off_scaled;

endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
   import pcseq_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int RIDX_W        = 5,
   parameter int LINK_REG      = 31,
   parameter bit ZERO_TO_LINK  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLOW_W-1:0] flow_i,
   input  logic              ops_equal_i,
   input  logic              stall_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   pc_plus_i,
   input  logic [XLEN-1:0]   br_tgt_i,
   input  logic [XLEN-1:0]   jabs_tgt_i,
   input  logic [XLEN-1:0]   reg_tgt_i,
   input  logic [RIDX_W-1:0] link_dst_i,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              link_we_o,
   output logic [RIDX_W-1:0] link_idx_o
);
   localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

   if (LINK_REG >= (1 << RIDX_W)) begin : g_bad_link
      $error("pcseq_select: LINK_REG does not fit RIDX_W");
   end

   flow_e             kind;
   logic              taken;
   logic              wants_link;
   logic [RIDX_W-1:0] jreg_dst;

   always_comb kind = flow_e'(flow_i);

   if (ZERO_TO_LINK) begin : g_zero_default
      always_comb jreg_dst = (link_dst_i == '0) ? LINK_IDX : link_dst_i;
   end else begin : g_plain_dst
      always_comb jreg_dst = link_dst_i;
   end

   always_comb begin
      taken      = 1'b0;
      wants_link = 1'b0;
      next_pc_o  = pc_plus_i;
      link_idx_o = LINK_IDX;
      unique case (kind)
         FLOW_BR_EQ: begin
            taken = ops_equal_i;
            if (taken) next_pc_o = br_tgt_i;
         end
         FLOW_BR_NE: begin
            taken = !ops_equal_i;
            if (taken) next_pc_o = br_tgt_i;
         end
         FLOW_JABS:      next_pc_o = jabs_tgt_i;
         FLOW_JABS_LINK: begin
            next_pc_o  = jabs_tgt_i;
            wants_link = 1'b1;
         end
         FLOW_JREG:      next_pc_o = reg_tgt_i;
         FLOW_JREG_LINK: begin
            next_pc_o  = reg_tgt_i;
            wants_link = 1'b1;
            link_idx_o = jreg_dst;
         end
         default: next_pc_o = pc_plus_i;
      endcase
      if (stall_i) next_pc_o = pc_i;
      link_we_o = wants_link && !stall_i;
   end

   // R12: kinds without a link never request a write
   a_r12_no_link_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != FLOW_JABS_LINK && kind != FLOW_JREG_LINK) |-> !link_we_o);

   // R11: stall blocks the link write
   a_r11_stall_no_link: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> !link_we_o);

   // R4: untaken branch falls through to the incremented PC
   a_r4_untaken_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((kind == FLOW_BR_EQ && !ops_equal_i) || (kind == FLOW_BR_NE && ops_equal_i))
      && !stall_i |-> next_pc_o == pc_plus_i);

endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
   import pcseq_pkg::*;
#(
   parameter int          XLEN             = 32,
   parameter int          STEP             = 4,
   parameter int          OFF_W            = 16,
   parameter int          IDX_W            = 26,
   parameter int          REGION_W         = 4,
   parameter int          RIDX_W           = 5,
   parameter int          LINK_REG         = 31,
   parameter logic [31:0] RESET_VEC        = 32'h8000_0000,
   parameter bit          REGION_FROM_NEXT = 1'b1,
   parameter bit          ZERO_TO_LINK     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_i,
   input  logic [2:0]        flow_i,
   input  logic              ops_equal_i,
   input  logic [OFF_W-1:0]  br_off_i,
   input  logic [IDX_W-1:0]  jmp_idx_i,
   input  logic [XLEN-1:0]   reg_tgt_i,
   input  logic [RIDX_W-1:0] link_dst_i,
   output logic [XLEN-1:0]   pc_o,
   output logic              link_we_o,
   output logic [RIDX_W-1:0] link_idx_o,
   output logic [XLEN-1:0]   link_val_o
);
   localparam logic [XLEN-1:0] RESET_PC = XLEN'(RESET_VEC);
   localparam logic [XLEN-1:0] STEP_V   = XLEN'(STEP);

   if (XLEN < 8) begin : g_bad_xlen
      $error("pcseq_unit: XLEN too small");
   end
   if ((RESET_VEC % STEP) != 0) begin : g_bad_vec
      $error("pcseq_unit: reset vector not aligned to STEP");
   end

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc_plus;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jabs_tgt;
   logic [XLEN-1:0] next_pc;

   pcseq_incr #(.XLEN(XLEN), .STEP(STEP)) u_incr (
      .pc_i      (pc_q),
      .pc_plus_o (pc_plus)
   );

   pcseq_target #(
      .XLEN(XLEN), .STEP(STEP), .OFF_W(OFF_W), .IDX_W(IDX_W),
      .REGION_W(REGION_W), .REGION_FROM_NEXT(REGION_FROM_NEXT)
   ) u_target (
      .pc_i       (pc_q),
      .pc_plus_i  (pc_plus),
      .off_i      (br_off_i),
      .idx_i      (jmp_idx_i),
      .br_tgt_o   (br_tgt),
      .jabs_tgt_o (jabs_tgt)
   );

   pcseq_select #(
      .XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG), .ZERO_TO_LINK(ZERO_TO_LINK)
   ) u_select (
      .clk         (clk),
      .rst_n       (rst_n),
      .flow_i      (flow_i),
      .ops_equal_i (ops_equal_i),
      .stall_i     (stall_i),
      .pc_i        (pc_q),
      .pc_plus_i   (pc_plus),
      .br_tgt_i    (br_tgt),
      .jabs_tgt_i  (jabs_tgt),
      .reg_tgt_i   (reg_tgt_i),
      .link_dst_i  (link_dst_i),
      .next_pc_o   (next_pc),
      .link_we_o   (link_we_o),
      .link_idx_o  (link_idx_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= next_pc;
   end

   always_comb pc_o       = pc_q;
   always_comb link_val_o = pc_plus;

   // R1: reset loads the kernel start address
   a_r1_reset_vector: assert property (@(posedge clk)
      !rst_n |=> pc_o == RESET_PC);

   // R2: sequential flow steps by one word
   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_i == FLOW_SEQ && !stall_i) |=> pc_o == $past(pc_o) + STEP_V);

   // R10: stall holds the PC
   a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> $stable(pc_o));

   // R6: register jump loads the full register value
   a_r6_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
      ((flow_i == FLOW_JREG || flow_i == FLOW_JREG_LINK) && !stall_i)
      |=> pc_o == $past(reg_tgt_i));

   // R5: absolute jump keeps the region of the incremented PC
   a_r5_region_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ((flow_i == FLOW_JABS || flow_i == FLOW_JABS_LINK) && !stall_i)
      |=> pc_o[XLEN-1 -: REGION_W] == $past(pc_plus[XLEN-1 -: REGION_W]));

   // R7: a link write always carries the return address
   a_r7_link_value: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> link_val_o == pc_o + STEP_V);

endmodule

// File: tb/sim_pcseq_unit.sv
module sim_pcseq_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        stall_i;
   logic [2:0]  flow_i;
   logic        ops_equal_i;
   logic [15:0] br_off_i;
   logic [25:0] jmp_idx_i;
   logic [31:0] reg_tgt_i;
   logic [4:0]  link_dst_i;
   logic [31:0] pc_o;
   logic        link_we_o;
   logic [4:0]  link_idx_o;
   logic [31:0] link_val_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] mpc;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   bit          done = 1'b0;

   always #5 clk = ~clk;

   pcseq_unit u0 (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .flow_i(flow_i),
      .ops_equal_i(ops_equal_i), .br_off_i(br_off_i), .jmp_idx_i(jmp_idx_i),
      .reg_tgt_i(reg_tgt_i), .link_dst_i(link_dst_i), .pc_o(pc_o),
      .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: compare PC after each edge with the queued expectation
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, pc_o, e);
      end
   end

   // driver: apply one instruction's controls, check link outputs, queue next PC
   task automatic step(input string req, input logic [2:0] kind, input logic eq,
                       input logic [15:0] off, input logic [25:0] idx,
                       input logic [31:0] rt, input logic [4:0] dst, input logic stl);
      logic [31:0] inc, nx, ext;
      logic        lw;
      logic [4:0]  li;
      flow_i = kind; ops_equal_i = eq; br_off_i = off; jmp_idx_i = idx;
      reg_tgt_i = rt; link_dst_i = dst; stall_i = stl;
      inc = mpc + 32'd4;
      ext = {{14{off[15]}}, off, 2'b00};
      nx = inc; lw = 1'b0; li = 5'd31;
      case (kind)
         3'd1: if (eq)  nx = inc + ext;
         3'd2: if (!eq) nx = inc + ext;
         3'd3: nx = {inc[31:28], idx, 2'b00};
         3'd4: begin nx = {inc[31:28], idx, 2'b00}; lw = 1'b1; end
         3'd5: nx = rt;
         3'd6: begin nx = rt; lw = 1'b1; li = (dst == 5'd0) ? 5'd31 : dst; end
         default: nx = inc;
      endcase
      if (stl) begin nx = mpc; lw = 1'b0; end
      #1;
      check({req, " link_we"}, {31'd0, link_we_o}, {31'd0, lw});
      if (lw) begin
         check({req, " link_idx"}, {27'd0, link_idx_o}, {27'd0, li});
         check({req, " link_val"}, link_val_o, inc);
      end
      exp_q.push_back(nx);
      tag_q.push_back(req);
      mpc = nx;
      @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; stall_i = 1'b0; flow_i = 3'd0; ops_equal_i = 1'b0;
      br_off_i = '0; jmp_idx_i = '0; reg_tgt_i = '0; link_dst_i = '0;
      repeat (2) @(negedge clk);
      check("R1 reset pc", pc_o, 32'h8000_0000);
      rst_n = 1'b1;
      mpc = 32'h8000_0000;
      step("R2 seq",            3'd0, 1'b0, 16'h0000, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R2 R12 seq",        3'd0, 1'b1, 16'h1234, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R4 beq taken",      3'd1, 1'b1, 16'h0003, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R4 beq untaken",    3'd1, 1'b0, 16'h0003, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R3 bne backward",   3'd2, 1'b0, 16'hFFFE, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R4 bne untaken",    3'd2, 1'b1, 16'hFFFE, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R3 self branch",    3'd1, 1'b1, 16'hFFFF, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R3 self again",     3'd2, 1'b0, 16'hFFFF, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R6 reg jump",       3'd5, 1'b0, 16'h0, 26'h0, 32'h8FFF_FFFC, 5'd0, 1'b0);
      step("R5 abs jump region",3'd3, 1'b0, 16'h0, 26'h000_0010, 32'h0, 5'd0, 1'b0);
      step("R7 abs jump link",  3'd4, 1'b0, 16'h0, 26'h3FF_FFFF, 32'h0, 5'd0, 1'b0);
      step("R8 reg jump link",  3'd6, 1'b0, 16'h0, 26'h0, 32'h0000_1000, 5'd7, 1'b0);
      step("R9 zero dest",      3'd6, 1'b0, 16'h0, 26'h0, 32'h0000_2000, 5'd0, 1'b0);
      step("R10 R11 stall jreg",3'd6, 1'b0, 16'h0, 26'h0, 32'h1234_5678, 5'd3, 1'b1);
      step("R10 R11 stall jal", 3'd4, 1'b0, 16'h0, 26'h0AB_CDEF, 32'h0, 5'd0, 1'b1);
      step("R12 reserved code", 3'd7, 1'b1, 16'h0040, 26'h0, 32'hDEAD_BEEC, 5'd9, 1'b0);
      step("R12 plain jreg",    3'd5, 1'b0, 16'h0, 26'h0, 32'hFFFF_FFFC, 5'd0, 1'b0);
      step("R2 wrap",           3'd0, 1'b0, 16'h0, 26'h0, 32'h0, 5'd0, 1'b0);
      step("R5 abs jump low",   3'd3, 1'b0, 16'h0, 26'h123_4567, 32'h0, 5'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset again", pc_o, 32'h8000_0000);
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule